// File: doc/BRIEF.md
# Video Sync Presence Detector

This block decides whether a video source is carrying valid sync. It watches a one-bit comparator result, sampled on the system clock. The comparator is high whenever the clamped video lies beyond the sync threshold. The block cuts that stream into fixed line windows and counts the high samples in each window. It then classifies each line by its duty cycle, with a band of hysteresis between two thresholds. The reported flag only moves after the new classification has held for a run of consecutive lines, so brief disturbances such as tuner noise cannot toggle it.

Two comparator sources are wired in. One watches the input path and the other watches the output path, and a select bit picks between them. When the selection changes, everything restarts from the no-sync state. The single output flag is meant to feed a status register bit.

Top module: `sync_presence_detect`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `sync_present` is 0. Measurement, hysteresis state and the persistence count all start afresh after `rst` falls.
- R2: A line window is exactly `LINE_CYCLES` clock cycles long. The first window starts on the first clock edge after reset or a source restart, and each window counts the clocks on which the selected comparator is 1.
- R3: A line whose high count times 100 is strictly greater than `LINE_CYCLES * HI_PCT` is classified present. With 100-cycle lines and the 91 % default, 92 high samples is present and 91 is not.
- R4: A line whose high count times 100 is strictly less than `LINE_CYCLES * LO_PCT` is classified absent. With 100-cycle lines and the 84 % default, 83 high samples is absent and 84 is not.
- R5: A line falling between the two thresholds, inclusive of both limits, keeps the classification of the previous line. After a reset or restart, that previous classification is absent.
- R6: `sync_present` changes only when `HOLD_LINES` consecutive lines (default 14) have all been classified opposite to it. Any line that agrees with the flag restarts the run. The new value appears one clock after the edge that samples the last cycle of the deciding line.
- R7: With `src_sel` = 1 the input-path comparator `cmp_in_path` is measured, and with `src_sel` = 0 the output-path comparator `cmp_out_path` is measured. The unselected comparator has no effect on `sync_present`.
- R8: When `src_sel` differs from its value at the previous clock edge, `sync_present` goes to 0 after that edge, and the line window, high count, hysteresis state and persistence count all restart. The sample taken on that edge is discarded.
- R9: `sync_present` = 1 means sync is present and 0 means no sync. The flag is a registered output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_in_path | input | 1 | Sync comparator result for the input path |
| cmp_out_path | input | 1 | Sync comparator result for the output path |
| src_sel | input | 1 | Source select: 1 selects the input path, 0 the output path |
| sync_present | output | 1 | Registered flag: 1 when sync is present |

## Verification
The bench aims at the exact threshold counts: 91 and 92 high samples, and 83 and 84 high samples. A design that used inclusive comparisons, or that dropped or doubled the last sample of a window, would classify one of these lines wrongly. It also feeds runs of 13 disagreeing lines broken by a single agreeing line, and runs of mid-band lines on both sides of the flag. A filter that does not clear its count, or that sets the hysteresis state from the reported flag instead of the last line, would flip the flag early or late. Finally, it drives the two comparator paths with opposite patterns and then switches the source while the flag is set. A swapped select, or a switch that did not clear the flag and the partial line, would show up directly on `sync_present`.

// File: rtl/sync_det_pkg.sv
package sync_det_pkg;
  typedef enum logic {
    VERD_ABSENT  = 1'b0,
    VERD_PRESENT = 1'b1
  } verdict_e;
endpackage

// File: rtl/sd_line_meter.sv
module sd_line_meter #(
  parameter int LINE_CYCLES = 12800,
  localparam int CNT_W = $clog2(LINE_CYCLES + 1),
  localparam int PH_W  = $clog2(LINE_CYCLES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             cmp,
  output logic             line_done,
  output logic [CNT_W-1:0] line_high
);
  localparam logic [PH_W-1:0] LAST = PH_W'(LINE_CYCLES - 1);

  logic [PH_W-1:0]  phase;
  logic [CNT_W-1:0] acc;
  logic [CNT_W-1:0] acc_next;

  assign acc_next = acc + CNT_W'(cmp);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      phase     <= '0;
      acc       <= '0;
      line_done <= 1'b0;
      line_high <= '0;
    end else begin
      line_done <= 1'b0;
      if (phase == LAST) begin
        phase     <= '0;
        acc       <= '0;
        line_done <= 1'b1;
        line_high <= acc_next;
      end else begin
        phase <= phase + 1'b1;
        acc   <= acc_next;
      end
    end
  end
endmodule

// File: rtl/sd_duty_classifier.sv
module sd_duty_classifier
  import sync_det_pkg::*;
#(
  parameter int LINE_CYCLES = 12800,
  parameter int HI_PCT      = 91,
  parameter int LO_PCT      = 84,
  localparam int CNT_W = $clog2(LINE_CYCLES + 1),
  localparam int PW    = CNT_W + 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             line_done,
  input  logic [CNT_W-1:0] line_high,
  output verdict_e         verdict
);
  localparam logic [PW-1:0] HI_LIM = PW'(LINE_CYCLES * HI_PCT);
  localparam logic [PW-1:0] LO_LIM = PW'(LINE_CYCLES * LO_PCT);

  verdict_e        last_q;
  logic [PW-1:0]   scaled;

  assign scaled = PW'(line_high) * PW'(100);

  always_comb begin
    if (scaled > HI_LIM)      verdict = VERD_PRESENT;
    else if (scaled < LO_LIM) verdict = VERD_ABSENT;
    else                      verdict = last_q;
  end

  always_ff @(posedge clk) begin
    if (rst || restart)  last_q <= VERD_ABSENT;
    else if (line_done)  last_q <= verdict;
  end
endmodule

// File: rtl/sd_persist_filter.sv
module sd_persist_filter
  import sync_det_pkg::*;
#(
  parameter int HOLD_LINES = 14,
  localparam int HW = $clog2(HOLD_LINES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          line_done,
  input  verdict_e      verdict,
  output logic          flag,
  output logic [HW-1:0] hold_cnt
);
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_LINES - 1);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      flag     <= 1'b0;
      hold_cnt <= '0;
    end else if (line_done) begin
      if (verdict == verdict_e'(flag)) begin
        hold_cnt <= '0;
      end else if (hold_cnt == HOLD_LAST) begin
        flag     <= (verdict == VERD_PRESENT);
        hold_cnt <= '0;
      end else begin
        hold_cnt <= hold_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sync_presence_detect.sv
module sync_presence_detect
  import sync_det_pkg::*;
#(
  parameter int LINE_CYCLES = 12800,
  parameter int HI_PCT      = 91,
  parameter int LO_PCT      = 84,
  parameter int HOLD_LINES  = 14,
  localparam int CNT_W = $clog2(LINE_CYCLES + 1),
  localparam int HW    = $clog2(HOLD_LINES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic cmp_in_path,
  input  logic cmp_out_path,
  input  logic src_sel,
  output logic sync_present
);
  logic             sel_q;
  logic             restart;
  logic             cmp_sel;
  logic             line_done;
  logic [CNT_W-1:0] line_high;
  verdict_e         verdict;
  logic [HW-1:0]    hold_cnt;

  always_ff @(posedge clk) begin
    sel_q <= src_sel;
  end

  assign restart = !rst && (src_sel != sel_q);
  assign cmp_sel = src_sel ? cmp_in_path : cmp_out_path;

  sd_line_meter #(.LINE_CYCLES(LINE_CYCLES)) u_meter (
    .clk       (clk),
    .rst       (rst),
    .restart   (restart),
    .cmp       (cmp_sel),
    .line_done (line_done),
    .line_high (line_high)
  );

  sd_duty_classifier #(
    .LINE_CYCLES (LINE_CYCLES),
    .HI_PCT      (HI_PCT),
    .LO_PCT      (LO_PCT)
  ) u_class (
    .clk       (clk),
    .rst       (rst),
    .restart   (restart),
    .line_done (line_done),
    .line_high (line_high),
    .verdict   (verdict)
  );

  sd_persist_filter #(.HOLD_LINES(HOLD_LINES)) u_filt (
    .clk       (clk),
    .rst       (rst),
    .restart   (restart),
    .line_done (line_done),
    .verdict   (verdict),
    .flag      (sync_present),
    .hold_cnt  (hold_cnt)
  );
endmodule

// File: rtl/sync_presence_detect_chk.sv
module sync_presence_detect_chk #(
  parameter int LINE_CYCLES = 12800,
  parameter int HOLD_LINES  = 14,
  localparam int CNT_W = $clog2(LINE_CYCLES + 1),
  localparam int HW    = $clog2(HOLD_LINES + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             src_sel,
  input logic             sync_present,
  input logic             restart,
  input logic             line_done,
  input logic [CNT_W-1:0] line_high,
  input logic             verdict,
  input logic [HW-1:0]    hold_cnt
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> !sync_present); // R1

  AST_HIGH_BOUND: assert property (@(posedge clk) disable iff (rst)
    line_done |-> (line_high <= CNT_W'(LINE_CYCLES))); // R2

  AST_RISE_NEEDS_PRESENT: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_present) |-> ($past(line_done) && $past(verdict))); // R3

  AST_FALL_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $fell(sync_present) |-> ($past(restart) || ($past(line_done) && !$past(verdict)))); // R4

  AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (rst)
    hold_cnt < HW'(HOLD_LINES)); // R6

  AST_FLAG_STEADY: assert property (@(posedge clk) disable iff (rst)
    (!line_done && !restart) |=> $stable(sync_present)); // R6

  AST_SRC_SWITCH: assert property (@(posedge clk) disable iff (rst)
    (src_sel != $past(src_sel)) |=> !sync_present); // R8
endmodule

bind sync_presence_detect sync_presence_detect_chk #(
  .LINE_CYCLES (LINE_CYCLES),
  .HOLD_LINES  (HOLD_LINES)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .src_sel      (src_sel),
  .sync_present (sync_present),
  .restart      (restart),
  .line_done    (line_done),
  .line_high    (line_high),
  .verdict      (verdict),
  .hold_cnt     (hold_cnt)
);

// File: tb/sync_presence_detect_bench.sv
`timescale 1ns/1ps
module sync_presence_detect_bench;
  localparam int LINE = 100;
  localparam int HI   = 91;
  localparam int LO   = 84;
  localparam int HOLD = 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmp_in_path = 1'b0;
  logic cmp_out_path = 1'b0;
  logic src_sel = 1'b1;
  logic sync_present;

  int n_vec = 0;
  int n_err = 0;
  logic chk_now = 1'b0;
  bit   exp_q[$];
  string tag_q[$];

  bit m_hyst = 1'b0;
  bit m_flag = 1'b0;
  int m_cnt  = 0;

  always #2.5 clk = ~clk;

  sync_presence_detect #(
    .LINE_CYCLES (LINE),
    .HI_PCT      (HI),
    .LO_PCT      (LO),
    .HOLD_LINES  (HOLD)
  ) u_sync_presence_detect (
    .clk          (clk),
    .rst          (rst),
    .cmp_in_path  (cmp_in_path),
    .cmp_out_path (cmp_out_path),
    .src_sel      (src_sel),
    .sync_present (sync_present)
  );

  task automatic check(input bit exp, input string tag);
    n_vec++;
    if (sync_present !== exp) begin
      n_err++;
      $display("FAIL %s: sync_present=%b expected %b at %0t", tag, sync_present, exp, $time);
    end
  endtask

  // monitor: pops the expected flag for the previous line mid-way through the next one
  always @(negedge clk) begin
    if (chk_now && exp_q.size() > 0) begin
      automatic bit e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      check(e, t);
    end
  end

  function automatic void model_reset();
    m_hyst = 1'b0; m_flag = 1'b0; m_cnt = 0;
  endfunction

  // expected behaviour taken from R3..R6
  function automatic void model_line(input int h, input string tag);
    bit v;
    if (h * 100 > LINE * HI)      v = 1'b1;
    else if (h * 100 < LINE * LO) v = 1'b0;
    else                          v = m_hyst;
    m_hyst = v;
    if (v == m_flag) m_cnt = 0;
    else if (m_cnt == HOLD - 1) begin m_flag = v; m_cnt = 0; end
    else m_cnt++;
    exp_q.push_back(m_flag);
    tag_q.push_back(tag);
  endfunction

  task automatic put(input bit p);
    if (src_sel) begin cmp_in_path = p;  cmp_out_path = ~p; end
    else         begin cmp_out_path = p; cmp_in_path  = ~p; end
  endtask

  task automatic drive_line(input int h, input string tag);
    for (int i = 0; i < LINE; i++) begin
      put(i < h);
      chk_now = (i == 10);
      @(posedge clk); #1;
    end
    chk_now = 1'b0;
    model_line(h, tag);
  endtask

  task automatic drive_lines(input int n, input int h, input string tag);
    for (int k = 0; k < n; k++) drive_line(h, tag);
  endtask

  task automatic flush();
    for (int i = 0; i < 20; i++) begin
      put(1'b0);
      chk_now = (i == 10);
      @(posedge clk); #1;
    end
    chk_now = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(1'b0, "R1 flag during reset");
    @(posedge clk); #1;
    rst = 1'b0;
    model_reset();
    check(1'b0, "R1 flag after reset");

    // R6/R3: full-duty lines need the whole hold run before the flag rises
    drive_lines(13, 100, "R6 hold before rise");
    drive_line(100, "R3 rise after hold run");
    // R5: mid-band lines keep the present state
    drive_lines(16, 88, "R5 mid-band keeps present");
    // R3/R4/R5 exact thresholds
    drive_line(91, "R3 91 pct not above threshold");
    drive_line(84, "R4 84 pct not below threshold");
    drive_line(83, "R4 83 pct absent");
    drive_line(84, "R5 84 keeps absent");
    drive_line(91, "R5 91 keeps absent");
    drive_line(92, "R3 92 pct present");
    // R6: a single agreeing line restarts the run
    drive_lines(13, 0, "R6 run of 13 absent");
    drive_line(100, "R6 agreeing line clears run");
    drive_lines(13, 0, "R6 second run of 13");
    drive_line(0, "R4 fall after hold run");
    drive_lines(16, 88, "R5 mid-band keeps absent");
    drive_lines(14, 100, "R9 present again");
    flush();

    // R8: switching the source clears the flag at once
    src_sel = 1'b0;
    put(1'b1);
    @(posedge clk); #1;
    model_reset();
    check(1'b0, "R8 flag cleared on source switch");
    // R7: output path now measured, input path driven inverted and ignored
    drive_lines(13, 100, "R7 output path hold");
    drive_line(100, "R7 output path rise");
    drive_lines(3, 50, "R7 output path mid");
    flush();

    // R1: reset in mid-run
    rst = 1'b1;
    @(posedge clk); #1;
    check(1'b0, "R1 flag cleared by reset");
    @(posedge clk); #1;
    rst = 1'b0;
    model_reset();
    drive_lines(3, 100, "R1 counts restart after reset");
    flush();

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    #(100000 * 5);
    n_err++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule